// File: doc/BRIEF.md
# Mode-Banked Register Switch Unit

This unit keeps the processor-mode-dependent copies of the upper general registers and swaps them in and out of the live register set whenever the processor changes mode. Every mode has its own stack pointer (r13), link register (r14) and saved status word. Fast-interrupt mode also owns a private copy of r8 to r12, which it trades against a shared copy used by every other mode.

The unit tracks the current mode itself. A one-cycle switch strobe with a requested mode moves the registers in a single clock. The new live values appear on the cycle after the strobe. A write port and a combinational read port give access to the live r8 to r14 and the live saved status word. A requested mode that is not a defined encoding raises an illegal-mode flag and is refused.

Top module: `banked_mode_regs`

## Requirements
- R1: After reset the current mode is supervisor (0x13), every live register and every stored copy reads zero, and the illegal flag is low.
- R2: Mode encodings are user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. They map to storage slots user/system→0, supervisor→1, abort→2, undefined→3, interrupt→4, fast interrupt→5, so user and system share one slot.
- R3: A switch strobe whose requested mode equals the current mode moves no register and leaves the mode unchanged.
- R4: On leaving fast-interrupt mode, live r8–r12 are saved to the fast-interrupt copy and the shared copy is loaded into r8–r12.
- R5: On entering fast-interrupt mode from any other mode, live r8–r12 are saved to the shared copy and the fast-interrupt copy is loaded into r8–r12.
- R6: On every real switch, live r13, r14 and the saved status word are stored into the old mode's slot, and the new mode's slot is then loaded into them. When both modes use the same slot, the live values are kept.
- R7: When the strobe carries a mode value outside R2, the illegal flag is high in that same cycle, and neither the mode nor any register changes.
- R8: A legal switch completes on the strobe's clock edge. The new mode and new live values are visible from the next cycle.
- R9: A write with select 0–4 sets live r8–r12, select 5 sets r13, select 6 sets r14 and select 7 sets the saved status word. The read port returns the same register for the same select, combinationally.
- R10: A write presented in the same cycle as any switch strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swReq | input | 1 | Mode switch strobe |
| reqMode | input | 5 | Requested mode encoding |
| wrEn | input | 1 | Live register write enable |
| wrSel | input | 3 | Live register write select |
| wrData | input | DATA_W | Write data |
| rdSel | input | 3 | Live register read select |
| rdData | output | DATA_W | Read data for rdSel |
| curMode | output | 5 | Current mode encoding |
| illegalMode | output | 1 | Strobe carries an undefined mode |

## Verification
Random streams mix legal switches, illegal encodings, repeated current-mode strobes and writes. A reference model tracks every stored copy. Any misrouted slot, lost save or wrong r8–r12 copy therefore shows up after a later return to the affected mode. Directed sequences give each mode a distinct stack pointer and then revisit the modes. This separates per-mode slots from the single slot shared by user and system. Fast-interrupt entry and exit with distinct r8–r12 contents separate the two low-register copies. A write held together with a strobe shows whether writes are dropped.

// File: rtl/mode_bank_pkg.sv
package mode_bank_pkg;

  typedef logic [4:0] mode_t;

  localparam mode_t MODE_USR = 5'h10;
  localparam mode_t MODE_FIQ = 5'h11;
  localparam mode_t MODE_IRQ = 5'h12;
  localparam mode_t MODE_SVC = 5'h13;
  localparam mode_t MODE_ABT = 5'h17;
  localparam mode_t MODE_UND = 5'h1B;
  localparam mode_t MODE_SYS = 5'h1F;

  localparam int unsigned SLOT_W   = 3;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned SEL_SP   = 5;
  localparam int unsigned SEL_LR   = 6;
  localparam int unsigned SEL_ST   = 7;

  typedef struct packed {
    logic              swap;
    logic              enterFiq;
    logic              leaveFiq;
    logic [SLOT_W-1:0] oldSlot;
    logic [SLOT_W-1:0] newSlot;
    logic              wrLive;
    logic [SEL_W-1:0]  wrSel;
  } bankCtl_t;

  function automatic logic modeIsLegal(input mode_t m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: modeIsLegal = 1'b1;
      default:                      modeIsLegal = 1'b0;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] modeSlot(input mode_t m);
    case (m)
      MODE_SVC: modeSlot = 3'd1;
      MODE_ABT: modeSlot = 3'd2;
      MODE_UND: modeSlot = 3'd3;
      MODE_IRQ: modeSlot = 3'd4;
      MODE_FIQ: modeSlot = 3'd5;
      default:  modeSlot = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import mode_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swReq,
  input  mode_t            reqMode,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  output bankCtl_t         ctl,
  output mode_t            curMode,
  output logic             illegalMode
);

  logic reqLegal;
  logic realSwitch;

  assign reqLegal    = modeIsLegal(reqMode);
  assign illegalMode = swReq && !reqLegal;
  assign realSwitch  = swReq && reqLegal && (reqMode != curMode);

  always_comb begin
    ctl          = '0;
    ctl.swap     = realSwitch;
    ctl.enterFiq = realSwitch && (reqMode == MODE_FIQ);
    ctl.leaveFiq = realSwitch && (curMode == MODE_FIQ);
    ctl.oldSlot  = modeSlot(curMode);
    ctl.newSlot  = modeSlot(reqMode);
    ctl.wrLive   = wrEn && !swReq;
    ctl.wrSel    = wrSel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) curMode <= MODE_SVC;
    else if (realSwitch) curMode <= reqMode;
  end

  // R7: a refused strobe leaves the mode in place
  assert_illegal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegalMode |=> $stable(curMode));

  // R3: same-mode strobe keeps the mode
  assert_same_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (swReq && reqMode == curMode) |=> $stable(curMode));

  // R8: legal strobe lands the requested mode on the next cycle
  assert_switch_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (swReq && !illegalMode) |=> (curMode == $past(reqMode)));

  // R2: mode register only ever holds a defined encoding
  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    modeIsLegal(curMode));

endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import mode_bank_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_SLOTS = 6,
  parameter int unsigned NUM_LOW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bankCtl_t          ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] liveLo  [NUM_LOW];
  logic [DATA_W-1:0] usrCopy [NUM_LOW];
  logic [DATA_W-1:0] fiqCopy [NUM_LOW];
  logic [DATA_W-1:0] liveSp, liveLr, liveSt;
  logic [DATA_W-1:0] slotSp  [NUM_SLOTS];
  logic [DATA_W-1:0] slotLr  [NUM_SLOTS];
  logic [DATA_W-1:0] slotSt  [NUM_SLOTS];
  logic              sameSlot;

  assign sameSlot = (ctl.oldSlot == ctl.newSlot);

  // r8..r12 and their two copies
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LOW; i++) begin
        liveLo[i]  <= '0;
        usrCopy[i] <= '0;
        fiqCopy[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_LOW; i++) begin
        if (ctl.leaveFiq) begin
          fiqCopy[i] <= liveLo[i];
          liveLo[i]  <= usrCopy[i];
        end else if (ctl.enterFiq) begin
          usrCopy[i] <= liveLo[i];
          liveLo[i]  <= fiqCopy[i];
        end else if (ctl.wrLive && (ctl.wrSel == SEL_W'(i))) begin
          liveLo[i]  <= wrData;
        end
      end
    end
  end

  // per-mode storage slots
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_SLOTS; b++) begin
        slotSp[b] <= '0;
        slotLr[b] <= '0;
        slotSt[b] <= '0;
      end
    end else if (ctl.swap) begin
      for (int b = 0; b < NUM_SLOTS; b++) begin
        if (ctl.oldSlot == SLOT_W'(b)) begin
          slotSp[b] <= liveSp;
          slotLr[b] <= liveLr;
          slotSt[b] <= liveSt;
        end
      end
    end
  end

  // live r13, r14, saved status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      liveSp <= '0;
      liveLr <= '0;
      liveSt <= '0;
    end else if (ctl.swap) begin
      if (!sameSlot) begin
        liveSp <= slotSp[ctl.newSlot];
        liveLr <= slotLr[ctl.newSlot];
        liveSt <= slotSt[ctl.newSlot];
      end
    end else if (ctl.wrLive) begin
      if (ctl.wrSel == SEL_W'(SEL_SP)) liveSp <= wrData;
      if (ctl.wrSel == SEL_W'(SEL_LR)) liveLr <= wrData;
      if (ctl.wrSel == SEL_W'(SEL_ST)) liveSt <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_LOW; i++)
      if (rdSel == SEL_W'(i)) rdData = liveLo[i];
    if (rdSel == SEL_W'(SEL_SP)) rdData = liveSp;
    if (rdSel == SEL_W'(SEL_LR)) rdData = liveLr;
    if (rdSel == SEL_W'(SEL_ST)) rdData = liveSt;
  end

  // R6: the old slot receives the live values on a switch
  assert_slot_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.swap |=> (slotSp[$past(ctl.oldSlot)] == $past(liveSp)) &&
                 (slotLr[$past(ctl.oldSlot)] == $past(liveLr)) &&
                 (slotSt[$past(ctl.oldSlot)] == $past(liveSt)));

  // R3: no strobe action and no write keeps r13/r14/status
  assert_live_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.swap && !ctl.wrLive) |=> $stable(liveSp) && $stable(liveLr) && $stable(liveSt));

  // R4 and R5: per-register checks on the low-register exchange
  for (genvar g = 0; g < NUM_LOW; g++) begin : g_lowChk
    assert_fiq_leave_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.leaveFiq |=> (liveLo[g] == $past(usrCopy[g])) && (fiqCopy[g] == $past(liveLo[g])));
    assert_fiq_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.enterFiq |=> (liveLo[g] == $past(fiqCopy[g])) && (usrCopy[g] == $past(liveLo[g])));
  end

endmodule

// File: rtl/banked_mode_regs.sv
module banked_mode_regs
  import mode_bank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swReq,
  input  logic [4:0]        reqMode,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic [4:0]        curMode,
  output logic              illegalMode
);

  localparam int unsigned NUM_SLOTS = 6;
  localparam int unsigned NUM_LOW   = 5;

  bankCtl_t ctl;

  bank_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .swReq       (swReq),
    .reqMode     (reqMode),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .ctl         (ctl),
    .curMode     (curMode),
    .illegalMode (illegalMode)
  );

  bank_datapath #(
    .DATA_W    (DATA_W),
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_LOW   (NUM_LOW)
  ) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .wrData (wrData),
    .rdSel  (rdSel),
    .rdData (rdData)
  );

endmodule

// File: tb/tb_banked_mode_regs.sv
`timescale 1ns/100ps
module tb_banked_mode_regs;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        swReq;
  logic [4:0]  reqMode;
  logic        wrEn;
  logic [2:0]  wrSel;
  logic [31:0] wrData;
  logic [2:0]  rdSel;
  logic [31:0] rdData;
  logic [4:0]  curMode;
  logic        illegalMode;

  int testCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  banked_mode_regs dut (
    .clk(clk), .rst_n(rst_n), .swReq(swReq), .reqMode(reqMode),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel),
    .rdData(rdData), .curMode(curMode), .illegalMode(illegalMode)
  );

  // reference state
  logic [31:0] mLive [8];
  logic [31:0] mUsr  [5];
  logic [31:0] mFiq  [5];
  logic [31:0] mSp   [6];
  logic [31:0] mLr   [6];
  logic [31:0] mSt   [6];
  logic [4:0]  mMode;

  function automatic bit legalM(input logic [4:0] m);
    return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
           m == 5'h17 || m == 5'h1B || m == 5'h1F;
  endfunction

  function automatic int slotM(input logic [4:0] m);
    case (m)
      5'h13: return 1;
      5'h17: return 2;
      5'h1B: return 3;
      5'h12: return 4;
      5'h11: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [4:0] legalPick(input int k);
    case (k % 7)
      0: return 5'h10; 1: return 5'h11; 2: return 5'h12; 3: return 5'h13;
      4: return 5'h17; 5: return 5'h1B; default: return 5'h1F;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 8; i++) mLive[i] = '0;
    for (int i = 0; i < 5; i++) begin mUsr[i] = '0; mFiq[i] = '0; end
    for (int i = 0; i < 6; i++) begin mSp[i] = '0; mLr[i] = '0; mSt[i] = '0; end
    mMode = 5'h13;
  endtask

  task automatic modelStep(input bit sw, input logic [4:0] m, input bit we,
                           input logic [2:0] sel, input logic [31:0] d);
    int o, n;
    if (we && !sw) mLive[sel] = d;
    if (sw && legalM(m) && m != mMode) begin
      o = slotM(mMode);
      n = slotM(m);
      if (mMode == 5'h11) begin
        for (int i = 0; i < 5; i++) begin mFiq[i] = mLive[i]; mLive[i] = mUsr[i]; end
      end else if (m == 5'h11) begin
        for (int i = 0; i < 5; i++) begin mUsr[i] = mLive[i]; mLive[i] = mFiq[i]; end
      end
      mSp[o] = mLive[5]; mLr[o] = mLive[6]; mSt[o] = mLive[7];
      mLive[5] = mSp[n]; mLive[6] = mLr[n]; mLive[7] = mSt[n];
      mMode = m;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // read every live register plus the mode, between clock edges
  task automatic checkAll(input string req);
    for (int s = 0; s < 8; s++) begin
      rdSel = 3'(s);
      #0.2;
      check(req, rdData, mLive[s]);
    end
    check(req, {27'd0, curMode}, {27'd0, mMode});
  endtask

  // one clock of stimulus; the result is checked after the following negedge
  task automatic step(input string req, input bit sw, input logic [4:0] m, input bit we,
                      input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    swReq = sw; reqMode = m; wrEn = we; wrSel = sel; wrData = d;
    #0.5;
    check({req, " R7 flag"}, {31'd0, illegalMode}, {31'd0, sw && !legalM(m)});
    @(posedge clk);
    modelStep(sw, m, we, sel, d);
    @(negedge clk);
    swReq = 1'b0; wrEn = 1'b0;
    checkAll(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++; testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; swReq = 1'b0; reqMode = 5'h10; wrEn = 1'b0;
    wrSel = '0; wrData = '0; rdSel = '0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    checkAll("R1 reset");
    check("R1 flag", {31'd0, illegalMode}, 32'd0);

    // R9: write each live register in supervisor mode
    for (int s = 0; s < 8; s++) step("R9 write", 0, 5'h10, 1, 3'(s), 32'h5000_0000 + s);

    // R2/R6: give each mode a distinct r13/r14/status, then revisit all
    for (int k = 0; k < 7; k++) begin
      step("R8 switch", 1, legalPick(k), 0, 0, 0);
      step("R9 sp", 0, 0, 1, 3'd5, 32'hA000_0000 + k);
      step("R9 lr", 0, 0, 1, 3'd6, 32'hB000_0000 + k);
      step("R9 st", 0, 0, 1, 3'd7, 32'hC000_0000 + k);
    end
    for (int k = 6; k >= 0; k--) step("R6 revisit", 1, legalPick(k), 0, 0, 0);
    // R2: user and system share a slot
    step("R2 to usr", 1, 5'h10, 0, 0, 0);
    step("R2 sp usr", 0, 0, 1, 3'd5, 32'h1234_5678);
    step("R2 to sys", 1, 5'h1F, 0, 0, 0);
    step("R2 back usr", 1, 5'h10, 0, 0, 0);

    // R5/R4: distinct low registers across fast-interrupt entry and exit
    for (int i = 0; i < 5; i++) step("R9 lo", 0, 0, 1, 3'(i), 32'hD100_0000 + i);
    step("R5 enter", 1, 5'h11, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R9 lo fiq", 0, 0, 1, 3'(i), 32'hE200_0000 + i);
    step("R4 leave", 1, 5'h12, 0, 0, 0);
    step("R5 reenter", 1, 5'h11, 0, 0, 0);
    step("R4 leave2", 1, 5'h13, 0, 0, 0);

    // R3: same-mode strobe, R7: illegal strobes, R10: write with strobe
    step("R3 same", 1, 5'h13, 0, 0, 0);
    step("R7 illegal", 1, 5'h00, 0, 0, 0);
    step("R7 illegal", 1, 5'h1E, 0, 0, 0);
    step("R10 drop", 1, 5'h17, 1, 3'd5, 32'hDEAD_BEEF);
    step("R10 drop same", 1, 5'h17, 1, 3'd0, 32'hDEAD_0001);
    step("R10 drop illegal", 1, 5'h14, 1, 3'd7, 32'hDEAD_0002);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 10);
      case (op)
        0, 1, 2, 3: step("R6 rand switch", 1, legalPick(int'($urandom % 7)), 0, 0, 0);
        4: step("R7 rand illegal", 1, 5'(($urandom % 16) + 5'h00), 0, 0, 0);
        5: step("R3 rand same", 1, mMode, 0, 0, 0);
        6: step("R10 rand", 1, legalPick(int'($urandom % 7)), 1, 3'($urandom % 8), $urandom);
        default: step("R9 rand write", 0, 0, 1, 3'($urandom % 8), $urandom);
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule